// File: doc/BRIEF.md
# Serial Fare Card Frame Port

This block moves 16-bit fare card frames over a single serial line, one bit at a time, with the most significant bit first. A divider inside the block makes one bit period from the system clock. At 125 MHz the default divisor of 1,250,000 gives a 10 ms bit. The block does not compute fares. It turns the serial frame into separate fields for the fare logic, and it writes back the frame that the fare logic supplies.

A read is started with `rd_start`. The first four bits received must match the fixed header `1010`. If they do not, the read stops after the fourth bit and the block raises `hdr_err`. If the header matches, the block keeps shifting bits in. A full read takes the whole frame and presents the balance, the rush-hour flag and the entry station. A short read, chosen with `rd_short`, stops after the header and balance, which is 11 bits. A write is started with `wr_start`. It first sends sixteen zero bits to erase the card, then sends the supplied frame.

Frame layout, with bit 15 sent first: bits 15:12 hold the header, bits 11:5 the balance in quarter-dollar units, bit 4 the rush flag (0 off-peak, 1 rush hour), and bits 3:0 the entry station. Before a passenger enters, the rush flag and station fields must be zero. A short read therefore reports both of them as zero.

The controller has five states:

| State | Meaning |
|---|---|
| `ST_IDLE` | Waiting for a start |
| `ST_RD_HEAD` | Receiving the four header bits |
| `ST_RD_BODY` | Receiving the rest of the frame |
| `ST_WR_ERASE` | Sending the sixteen erase zeros |
| `ST_WR_DATA` | Sending the new frame |

Its transitions are:

| From | To | When |
|---|---|---|
| `ST_IDLE` | `ST_RD_HEAD` | `rd_start` is high |
| `ST_IDLE` | `ST_WR_ERASE` | `wr_start` is high and `rd_start` is low |
| `ST_RD_HEAD` | `ST_RD_BODY` | the fourth bit arrives and the header matches |
| `ST_RD_HEAD` | `ST_IDLE` | the fourth bit arrives and the header does not match |
| `ST_RD_BODY` | `ST_IDLE` | bit 11 arrives (short read) or bit 16 arrives (full read) |
| `ST_WR_ERASE` | `ST_WR_DATA` | the sixteenth zero has been sent |
| `ST_WR_DATA` | `ST_IDLE` | the sixteenth frame bit has been sent |

Top module: `fcard_frame_port`

## Requirements
- R1: After reset, `busy`, `done`, `hdr_err`, `sout`, `sout_en`, `balance`, `rush` and `station` are all zero.
- R2: One bit lasts TICK_DIV clocks. During a read, bit k (k starting at 0) is sampled at the clock edge (k+1)*TICK_DIV edges after the edge that accepts the start.
- R3: A full read that passes the header check loads `balance` from frame bits 11:5, `rush` from bit 4 and `station` from bits 3:0. The frame arrives MSB first. The fields change only at the edge that ends a successful read.
- R4: The header, frame bits 15:12, must equal 1010. On a mismatch the read ends after the fourth bit and `hdr_err` goes high. `balance`, `rush` and `station` keep their previous values.
- R5: If `rd_short` is high when a read starts, the read ends after 11 bits. `balance` loads from bits 11:5, and `rush` and `station` are cleared to zero. `rd_short` is sampled only at the start.
- R6: A write sends 16 zero bits and then the 16 bits of `wr_frame`, MSB first. Each bit is held for TICK_DIV clocks, and `sout_en` stays high for all 32 bits.
- R7: `busy` is high from the edge that accepts a start up to the edge that ends the operation. `done` is high for exactly one clock, starting at that ending edge.
- R8: Start requests are ignored while `busy` is high. If `rd_start` and `wr_start` are both high in idle, the read is started.
- R9: `hdr_err` holds its value until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_start | input | 1 | Request to start a read |
| rd_short | input | 1 | Selects a short read; sampled together with `rd_start` |
| wr_start | input | 1 | Request to start an erase-then-write |
| wr_frame | input | 16 | Frame to write; captured when the write starts |
| sin | input | 1 | Serial data from the card |
| sout | output | 1 | Serial data to the card |
| sout_en | output | 1 | High while the block drives the card |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-clock pulse when an operation finishes |
| hdr_err | output | 1 | The last read failed the header check |
| balance | output | 7 | Balance in quarter-dollar units |
| rush | output | 1 | Rush-hour flag from the last full read |
| station | output | 4 | Entry station from the last full read |

## Verification
The bench builds the block with TICK_DIV set to 4, so one bit lasts four clocks. That shortens each frame enough to sweep all 128 balance values through full reads, all 15 wrong headers, sixteen short reads and twenty erase-then-write frames. With a short bit, the bench can sample the line in the middle of every bit period and check `done` in the exact cycle after each final bit, including the cycle just before it. Requests made during a read, and read and write requests made in the same clock, are run inside that sweep.

// File: rtl/fcard_pkg.sv
package fcard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_HEAD  = 3'd1,
        ST_RD_BODY  = 3'd2,
        ST_WR_ERASE = 3'd3,
        ST_WR_DATA  = 3'd4
    } port_state_e;

endpackage

// File: rtl/fcard_tick_gen.sv
module fcard_tick_gen #(
    parameter int unsigned DIV = 1250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    // The count restarts from zero whenever the enable is low.
    assign tick = en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/fcard_rx_shift.sv
module fcard_rx_shift #(
    parameter int          FRAME_W = 16,
    parameter int          HDR_W   = 4,
    parameter int          BAL_W   = 7,
    parameter int          STN_W   = 4,
    parameter logic [3:0]  HDR_VAL = 4'b1010
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             sin,
    input  logic             cap_full,
    input  logic             cap_short,
    output logic             hdr_ok,
    output logic [BAL_W-1:0] balance,
    output logic             rush,
    output logic [STN_W-1:0] station
);
    localparam int SHORT_W = HDR_W + BAL_W;
    localparam int BAL_LSB = STN_W + 1;

    logic [FRAME_W-2:0] sreg;
    logic [FRAME_W-1:0] word_full;
    logic [SHORT_W-1:0] word_short;

    // Each capture combines the bits already shifted in with the bit arriving now.
    assign word_full  = {sreg, sin};
    assign word_short = {sreg[SHORT_W-2:0], sin};
    assign hdr_ok     = ({sreg[HDR_W-2:0], sin} == HDR_VAL[HDR_W-1:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (shift_en) begin
            sreg <= word_full[FRAME_W-2:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            balance <= '0;
            rush    <= 1'b0;
            station <= '0;
        end else if (cap_full) begin
            balance <= word_full[BAL_LSB +: BAL_W];
            rush    <= word_full[STN_W];
            station <= word_full[STN_W-1:0];
        end else if (cap_short) begin
            balance <= word_short[BAL_W-1:0];
            rush    <= 1'b0;
            station <= '0;
        end
    end

    // R3
    field_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(balance) |-> $past(cap_full || cap_short));

endmodule

// File: rtl/fcard_tx_shift.sv
module fcard_tx_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               shift_en,
    input  logic [FRAME_W-1:0] frame,
    output logic               sout
);
    localparam int TW = 2 * FRAME_W;

    logic [TW-1:0] sreg;

    // The erase zeros sit above the frame, so one shift register holds the whole sequence.
    assign sout = sreg[TW-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= {{FRAME_W{1'b0}}, frame};
        end else if (shift_en) begin
            sreg <= {sreg[TW-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/fcard_frame_port.sv
module fcard_frame_port
    import fcard_pkg::*;
#(
    parameter int unsigned TICK_DIV = 1250000,
    parameter int          FRAME_W  = 16,
    parameter int          HDR_W    = 4,
    parameter int          BAL_W    = 7,
    parameter int          STN_W    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_start,
    input  logic               rd_short,
    input  logic               wr_start,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               sin,
    output logic               sout,
    output logic               sout_en,
    output logic               busy,
    output logic               done,
    output logic               hdr_err,
    output logic [BAL_W-1:0]   balance,
    output logic               rush,
    output logic [STN_W-1:0]   station
);
    localparam int CW = $clog2(FRAME_W + 1);
    localparam logic [CW-1:0] HDR_LAST   = CW'(HDR_W - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(HDR_W + BAL_W - 1);
    localparam logic [CW-1:0] FULL_LAST  = CW'(FRAME_W - 1);

    port_state_e    st, st_nx;
    logic [CW-1:0]  bit_cnt;
    logic           short_q;
    logic           tick;
    logic           hdr_ok;
    logic           accept;
    logic           rd_last_bit;
    logic           shift_rx, cap_full, cap_short, load_tx, shift_tx;

    assign accept      = (st == ST_IDLE) && (rd_start || wr_start);
    assign rd_last_bit = (bit_cnt == (short_q ? SHORT_LAST : FULL_LAST));

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next state.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (rd_start)      st_nx = ST_RD_HEAD;
                else if (wr_start) st_nx = ST_WR_ERASE;
            end
            ST_RD_HEAD: begin
                if (tick && bit_cnt == HDR_LAST)
                    st_nx = hdr_ok ? ST_RD_BODY : ST_IDLE;
            end
            ST_RD_BODY: begin
                if (tick && rd_last_bit) st_nx = ST_IDLE;
            end
            ST_WR_ERASE: begin
                if (tick && bit_cnt == FULL_LAST) st_nx = ST_WR_DATA;
            end
            ST_WR_DATA: begin
                if (tick && bit_cnt == FULL_LAST) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // Outputs and datapath strobes.
    always_comb begin
        busy      = 1'b0;
        sout_en   = 1'b0;
        shift_rx  = 1'b0;
        cap_full  = 1'b0;
        cap_short = 1'b0;
        load_tx   = 1'b0;
        shift_tx  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                load_tx = wr_start && !rd_start;
            end
            ST_RD_HEAD: begin
                busy     = 1'b1;
                shift_rx = tick;
            end
            ST_RD_BODY: begin
                busy      = 1'b1;
                shift_rx  = tick;
                cap_full  = tick && rd_last_bit && !short_q;
                cap_short = tick && rd_last_bit && short_q;
            end
            ST_WR_ERASE, ST_WR_DATA: begin
                busy     = 1'b1;
                sout_en  = 1'b1;
                shift_tx = tick;
            end
            default: ;
        endcase
    end

    // Bit counter, mode flag, completion pulse and header error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            short_q <= 1'b0;
            done    <= 1'b0;
            hdr_err <= 1'b0;
        end else begin
            done <= (st != ST_IDLE) && (st_nx == ST_IDLE);
            if (accept) begin
                bit_cnt <= '0;
                short_q <= rd_start && rd_short;
                hdr_err <= 1'b0;
            end else if (tick) begin
                if ((st == ST_WR_ERASE) && (bit_cnt == FULL_LAST)) bit_cnt <= '0;
                else                                               bit_cnt <= bit_cnt + 1'b1;
                if ((st == ST_RD_HEAD) && (bit_cnt == HDR_LAST) && !hdr_ok) hdr_err <= 1'b1;
            end
        end
    end

    fcard_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (busy),
        .tick (tick)
    );

    fcard_rx_shift #(
        .FRAME_W(FRAME_W), .HDR_W(HDR_W), .BAL_W(BAL_W), .STN_W(STN_W),
        .HDR_VAL(4'b1010)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_rx),
        .sin      (sin),
        .cap_full (cap_full),
        .cap_short(cap_short),
        .hdr_ok   (hdr_ok),
        .balance  (balance),
        .rush     (rush),
        .station  (station)
    );

    fcard_tx_shift #(.FRAME_W(FRAME_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_tx),
        .shift_en(shift_tx),
        .frame   (wr_frame),
        .sout    (sout)
    );

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    erase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WR_ERASE) |-> (!sout && sout_en));

    // R4
    hdr_err_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_err) |-> $past(st == ST_RD_HEAD));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !rd_start && !wr_start) |=> (st == ST_IDLE));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/sim_fcard_frame_port.sv
module sim_fcard_frame_port;
    localparam int DIV = 4;
    localparam int W   = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         rd_start, rd_short, wr_start, sin;
    logic [W-1:0] wr_frame;
    logic         sout, sout_en, busy, done, hdr_err, rush;
    logic [6:0]   balance;
    logic [3:0]   station;

    int n_vec = 0;
    int n_bad = 0;
    logic [6:0] m_bal  = '0;
    logic       m_rush = 1'b0;
    logic [3:0] m_stn  = '0;

    always #4 clk = ~clk;

    fcard_frame_port #(.TICK_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_short(rd_short),
        .wr_start(wr_start), .wr_frame(wr_frame), .sin(sin), .sout(sout),
        .sout_en(sout_en), .busy(busy), .done(done), .hdr_err(hdr_err),
        .balance(balance), .rush(rush), .station(station)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_read(input logic [15:0] f, input bit short, input bit both, input bit poke);
        bit good;
        int nb;
        good = (f[15:12] == 4'b1010);
        nb   = !good ? 4 : (short ? 11 : 16);
        @(negedge clk);
        rd_start = 1'b1; rd_short = short; wr_start = both;
        @(negedge clk);
        rd_start = 1'b0; wr_start = 1'b0; rd_short = !short;
        chk("R7", "busy at start", busy, 1);
        chk("R9", "hdr_err cleared", hdr_err, 0);
        chk("R8", "no write on read", sout_en, 0);
        for (int k = 0; k < nb; k++) begin
            sin = f[15-k];
            if (poke && k == 5) begin rd_start = 1'b1; wr_start = 1'b1; end
            if (k == nb - 1) begin
                repeat (3) @(negedge clk);
                chk("R2", "busy before last edge", busy, 1);
                chk("R7", "done early", done, 0);
                @(negedge clk);
            end else begin
                repeat (4) @(negedge clk);
            end
            if (poke && k == 5) begin
                chk("R8", "busy start ignored", sout_en, 0);
                rd_start = 1'b0; wr_start = 1'b0;
            end
        end
        if (good) begin
            m_bal  = f[11:5];
            m_rush = short ? 1'b0 : f[4];
            m_stn  = short ? 4'd0 : f[3:0];
        end
        chk("R7", "done at end", done, 1);
        chk("R7", "busy at end", busy, 0);
        chk("R4", "hdr_err", hdr_err, !good);
        chk(short ? "R5" : "R3", "balance", balance, m_bal);
        chk(good ? (short ? "R5" : "R3") : "R4", "rush", rush, m_rush);
        chk(good ? (short ? "R5" : "R3") : "R4", "station", station, m_stn);
        @(negedge clk);
        chk("R7", "done one cycle", done, 0);
        sin = 1'b0; rd_short = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] f);
        @(negedge clk);
        wr_start = 1'b1; wr_frame = f;
        @(negedge clk);
        wr_start = 1'b0; wr_frame = ~f;
        for (int j = 0; j < 32; j++) begin
            @(negedge clk);
            chk("R6", "sout", sout, (j < 16) ? 1'b0 : f[31-j]);
            chk("R6", "sout_en", sout_en, 1);
            repeat (3) @(negedge clk);
        end
        chk("R7", "write done", done, 1);
        chk("R7", "write busy end", busy, 0);
        chk("R6", "sout_en released", sout_en, 0);
        @(negedge clk);
        chk("R7", "write done one cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_start = 1'b0; rd_short = 1'b0; wr_start = 1'b0;
        sin = 1'b0; wr_frame = '0;
        repeat (3) @(negedge clk);
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "hdr_err", hdr_err, 0);
        chk("R1", "sout", sout, 0);
        chk("R1", "sout_en", sout_en, 0);
        chk("R1", "fields", {balance, rush, station}, 0);
        rst_n = 1'b1;

        for (int b = 0; b < 128; b++) begin
            logic [6:0] bv;
            bv = 7'(b);
            do_read({4'b1010, bv, bv[0] ^ bv[3], 4'(b * 5)}, 1'b0, b == 7, b == 20);
        end
        for (int h = 0; h < 16; h++) begin
            if (h != 10) do_read({4'(h), 7'h55, 1'b1, 4'h9}, 1'b0, 1'b0, 1'b0);
        end
        for (int s = 0; s < 16; s++) begin
            do_read({4'b1010, 7'(s * 8 + 3), 1'b1, 4'(s)}, 1'b1, s == 3, 1'b0);
        end
        do_write(16'h0000);
        do_write(16'hFFFF);
        for (int i = 0; i < 18; i++) begin
            do_write(16'(i * 16'h1357) ^ 16'hA5C3);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule